// File: doc/BRIEF.md
# Memory Built-In Self-Test Controller

This block tests a group of small on-chip memories by itself and reports one pass/fail flag for each. Software controls it through a single memory-mapped control/status word. A write to that word can wipe the results, launch a real March C- test of all memories, or launch a checker self-test in which every comparison is forced to miscompare. The forced run shows that the fail-flag path works before a real result is trusted.

All memories are exercised in parallel. They share one address counter, one write-data generator and one expected-value generator. Each memory has its own comparator and a sticky fail flag. Software starts a run and then polls the done bit. Once done reads 1, the fail field is valid. The memories sit outside the block and are synchronous single-port RAMs: read data appears on the cycle after the read request.

The test is the six-element March C- sequence over the full address range of each memory:
1. write 0, ascending
2. read 0 then write 1, ascending
3. read 1 then write 0, ascending
4. read 0 then write 1, descending
5. read 1 then write 0, descending
6. read 0, ascending

A read/write element spends two cycles per address. With D = 2^AW words per memory, a run takes 10·D memory cycles plus one final compare cycle.

Top module: `mbist_ctrl`

## Requirements
- R1: The control/status word responds only at byte address 0x0420_0000. A read at any other address returns 0. A write at any other address changes nothing.
- R2: After reset the control/status word reads 0, and no memory access is issued.
- R3: A write with bit 2 = 1 clears the done flag, all fail flags, the go bit and the check bit, so the word reads 0. This applies even during a run, which it aborts.
- R4: When bit 2 and bit 1 are both 1 in the same write, the clear wins and no run starts.
- R5: A write made while idle, with bit 2 = 0 and bit 1 (go) = 1, starts a run. Bit 1 then reads back 1 and bit 2 (done) reads 0 until the run ends.
- R6: A write made while idle with bit 0 (check) = 1 starts a run in which every comparison miscompares. At done, all fail flags are 1; with eight memories the word reads 0x7FD.
- R7: Done reads 1 exactly 10·D+1 clock edges after the edge that accepts the start write. That edge is the one after the final read compare.
- R8: A run over fault-free memories ends with every fail flag 0; a go run then reads 0x006.
- R9: A memory that returns a wrong value on any read of the march sets only its own fail flag, at bit 3+i for memory i.
- R10: Fail flags are sticky. Once set, they stay set through idle cycles and through non-clear writes, until a clear write or the next start.
- R11: While a run is in progress, a write with bit 2 = 0 is ignored: the control bits keep their values and the run continues unchanged.
- R12: The memory enable is low whenever no run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe of the register port |
| bus_addr | input | 32 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; the status word at the register address, else 0 |
| mem_en | output | 1 | Memory access request, shared by all memories |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Shared memory word address |
| mem_wdata | output | DW | Shared write data (all zeros or all ones) |
| mem_rdata | input | NMEM·DW | Read data, memory i in bits [i·DW +: DW], one cycle after the read |

## Verification
The following are checked by assertions on every cycle:
- the clear wipes every result and stops the sequencer, and wins over a simultaneous go;
- a start makes the block busy with done low;
- done rises right after the final compare;
- a forced compare sets every fail flag;
- fail flags never fall without a clear or start;
- non-clear writes during a run leave the control bits alone;
- the memories stay quiet when idle.

Some behaviours can only be shown by the bench's scenarios, in which a behavioural model predicts the status word every clock:
- the exact run length;
- the final words 0x7FD and 0x006;
- that a stuck bit in one memory lights only that memory's flag;
- that writes to other addresses are ignored.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  // Status word bit positions (software-visible, fixed)
  localparam int unsigned BIT_CHECK = 0;
  localparam int unsigned BIT_GO    = 1;
  localparam int unsigned BIT_CLR   = 2;  // write: clear, read: done
  localparam int unsigned BIT_FAIL0 = 3;

  localparam logic [2:0] EL_FIRST = 3'd0;
  localparam logic [2:0] EL_LAST  = 3'd5;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_FIN  = 2'd2
  } sq_state_e;

  // March C- element properties, element index 0..5
  function automatic logic el_has_read(input logic [2:0] e);
    return e != EL_FIRST;
  endfunction

  function automatic logic el_has_write(input logic [2:0] e);
    return e != EL_LAST;
  endfunction

  function automatic logic el_read_ones(input logic [2:0] e);
    return (e == 3'd2) || (e == 3'd4);
  endfunction

  function automatic logic el_write_ones(input logic [2:0] e);
    return (e == 3'd1) || (e == 3'd3);
  endfunction

  function automatic logic el_descending(input logic [2:0] e);
    return (e == 3'd3) || (e == 3'd4);
  endfunction

endpackage

// File: rtl/mbist_csr.sv
module mbist_csr
  import mbist_pkg::*;
#(
  parameter int unsigned NMEM     = 8,
  parameter logic [31:0] CSR_ADDR = 32'h0420_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [31:0]     bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic            busy,
  input  logic            seq_fin,
  input  logic [NMEM-1:0] fail_vec,
  output logic            wr_hit,
  output logic            start_evt,
  output logic            clr_evt,
  output logic            check_q,
  output logic            go_q,
  output logic            done_q
);

  logic        hit;
  logic        ctrl_wr;
  logic [31:0] word;
  logic        unused_wdata;

  assign hit          = (bus_addr == CSR_ADDR);
  assign wr_hit       = bus_wr && hit;
  assign clr_evt      = wr_hit && bus_wdata[BIT_CLR];
  assign ctrl_wr      = wr_hit && !bus_wdata[BIT_CLR] && !busy;
  assign start_evt    = ctrl_wr && (bus_wdata[BIT_GO] || bus_wdata[BIT_CHECK]);
  assign unused_wdata = ^bus_wdata[31:BIT_FAIL0];

  always_ff @(posedge clk) begin
    if (!rst_n || clr_evt) begin
      check_q <= 1'b0;
      go_q    <= 1'b0;
      done_q  <= 1'b0;
    end else if (ctrl_wr) begin
      check_q <= bus_wdata[BIT_CHECK];
      go_q    <= bus_wdata[BIT_GO];
      if (start_evt) done_q <= 1'b0;
    end else if (seq_fin) begin
      done_q <= 1'b1;
    end
  end

  always_comb begin
    word                   = '0;
    word[BIT_CHECK]        = check_q;
    word[BIT_GO]           = go_q;
    word[BIT_CLR]          = done_q;
    word[BIT_FAIL0 +: NMEM] = fail_vec;
  end

  assign bus_rdata = hit ? word : '0;

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          cmp_vld,
  output logic [DW-1:0] cmp_exp,
  output logic          busy,
  output logic          fin
);

  localparam logic [AW-1:0] MAXA = '1;

  sq_state_e     state_q;
  logic [2:0]    elem_q;
  logic [AW-1:0] addr_q;
  logic          phase_q;   // 0: read half, 1: write half of a r/w element
  logic          cmp_vld_q;
  logic [DW-1:0] cmp_exp_q;

  logic in_run, rd_cycle, wr_cycle, step, at_end, rw_elem;

  always_comb begin
    in_run   = (state_q == SQ_RUN);
    rw_elem  = el_has_read(elem_q) && el_has_write(elem_q);
    rd_cycle = in_run && el_has_read(elem_q) && (!el_has_write(elem_q) || !phase_q);
    wr_cycle = in_run && el_has_write(elem_q) && (!el_has_read(elem_q) || phase_q);
    step     = wr_cycle || (rd_cycle && !el_has_write(elem_q));
    at_end   = el_descending(elem_q) ? (addr_q == '0) : (addr_q == MAXA);
  end

  assign mem_en    = rd_cycle || wr_cycle;
  assign mem_we    = wr_cycle;
  assign mem_addr  = addr_q;
  assign mem_wdata = {DW{el_write_ones(elem_q)}};
  assign cmp_vld   = cmp_vld_q;
  assign cmp_exp   = cmp_exp_q;
  assign busy      = (state_q != SQ_IDLE);
  assign fin       = (state_q == SQ_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      state_q   <= SQ_IDLE;
      elem_q    <= EL_FIRST;
      addr_q    <= '0;
      phase_q   <= 1'b0;
      cmp_vld_q <= 1'b0;
      cmp_exp_q <= '0;
    end else begin
      cmp_vld_q <= rd_cycle;
      cmp_exp_q <= {DW{el_read_ones(elem_q)}};
      unique case (state_q)
        SQ_IDLE: begin
          if (start) begin
            state_q <= SQ_RUN;
            elem_q  <= EL_FIRST;
            addr_q  <= '0;
            phase_q <= 1'b0;
          end
        end
        SQ_RUN: begin
          if (rw_elem) phase_q <= ~phase_q;
          if (step) begin
            if (at_end) begin
              if (elem_q == EL_LAST) begin
                state_q <= SQ_FIN;
              end else begin
                elem_q  <= elem_q + 3'd1;
                addr_q  <= el_descending(elem_q + 3'd1) ? MAXA : '0;
                phase_q <= 1'b0;
              end
            end else begin
              addr_q <= el_descending(elem_q) ? addr_q - 1'b1 : addr_q + 1'b1;
            end
          end
        end
        SQ_FIN:  state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
  parameter int unsigned NMEM = 8,
  parameter int unsigned DW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wipe,
  input  logic               cmp_vld,
  input  logic [DW-1:0]      cmp_exp,
  input  logic               force_miss,
  input  logic [NMEM*DW-1:0] rdata,
  output logic [NMEM-1:0]    miss_vec,
  output logic [NMEM-1:0]    fail_vec
);

  for (genvar i = 0; i < NMEM; i++) begin : g_lane
    assign miss_vec[i] = cmp_vld && (force_miss || (rdata[i*DW +: DW] != cmp_exp));

    always_ff @(posedge clk) begin
      if (!rst_n || wipe) fail_vec[i] <= 1'b0;
      else if (miss_vec[i]) fail_vec[i] <= 1'b1;
    end
  end

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl #(
  parameter int unsigned NMEM     = 8,
  parameter int unsigned AW       = 4,
  parameter int unsigned DW       = 8,
  parameter logic [31:0] CSR_ADDR = 32'h0420_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [31:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               mem_en,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic [NMEM*DW-1:0] mem_rdata
);

  // Named internal events, observed by the bound checker
  logic            wr_hit, start_evt, clr_evt, wipe_evt;
  logic            check_q, go_q, done_q;
  logic            busy, seq_fin, cmp_vld;
  logic [DW-1:0]   cmp_exp;
  logic [NMEM-1:0] fail_vec, miss_vec;

  assign wipe_evt = clr_evt || start_evt;

  mbist_csr #(.NMEM(NMEM), .CSR_ADDR(CSR_ADDR)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .seq_fin   (seq_fin),
    .fail_vec  (fail_vec),
    .wr_hit    (wr_hit),
    .start_evt (start_evt),
    .clr_evt   (clr_evt),
    .check_q   (check_q),
    .go_q      (go_q),
    .done_q    (done_q)
  );

  mbist_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_evt),
    .abort     (clr_evt),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .cmp_vld   (cmp_vld),
    .cmp_exp   (cmp_exp),
    .busy      (busy),
    .fin       (seq_fin)
  );

  mbist_cmp #(.NMEM(NMEM), .DW(DW)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .wipe       (wipe_evt),
    .cmp_vld    (cmp_vld),
    .cmp_exp    (cmp_exp),
    .force_miss (check_q),
    .rdata      (mem_rdata),
    .miss_vec   (miss_vec),
    .fail_vec   (fail_vec)
  );

endmodule

// File: rtl/mbist_ctrl_chk.sv
module mbist_ctrl_chk #(
  parameter int unsigned NMEM = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_hit,
  input logic            wr_clr,
  input logic            wr_go,
  input logic            start_evt,
  input logic            wipe_evt,
  input logic            busy,
  input logic            seq_fin,
  input logic            cmp_vld,
  input logic            check_q,
  input logic            go_q,
  input logic            done_q,
  input logic [NMEM-1:0] fail_vec,
  input logic            mem_en
);

  p_clear_wipes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && wr_clr |=> !done_q && !go_q && !check_q && (fail_vec == '0) && !busy);

  p_clear_beats_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && wr_clr && wr_go |=> !busy && !go_q);

  p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy && !done_q);

  p_forced_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_vld && check_q && !wipe_evt |=> (&fail_vec));

  p_done_after_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fin && !wipe_evt |=> done_q && !busy);

  p_last_cmp_in_fin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fin |-> cmp_vld);

  p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wipe_evt |=> ((fail_vec & $past(fail_vec)) == $past(fail_vec)));

  p_busy_write_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_hit && !wr_clr |=> $stable(go_q) && $stable(check_q) && busy);

  p_mem_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);

endmodule

bind mbist_ctrl mbist_ctrl_chk #(.NMEM(NMEM)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_hit    (wr_hit),
  .wr_clr    (bus_wdata[2]),
  .wr_go     (bus_wdata[1]),
  .start_evt (start_evt),
  .wipe_evt  (wipe_evt),
  .busy      (busy),
  .seq_fin   (seq_fin),
  .cmp_vld   (cmp_vld),
  .check_q   (check_q),
  .go_q      (go_q),
  .done_q    (done_q),
  .fail_vec  (fail_vec),
  .mem_en    (mem_en)
);

// File: tb/sim_mbist_ctrl.sv
`timescale 1ns/1ps
module sim_mbist_ctrl;

  localparam int NM = 8;
  localparam int AWB = 4;
  localparam int DWB = 8;
  localparam int DEPTH = 1 << AWB;
  // one write sweep, four two-cycle sweeps, one read sweep, one last compare
  localparam int RUN_LEN = DEPTH + 4 * (2 * DEPTH) + DEPTH + 1;
  localparam logic [31:0] REG = 32'h0420_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_addr = REG;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic mem_en, mem_we;
  logic [AWB-1:0] mem_addr;
  logic [DWB-1:0] mem_wdata;
  logic [NM*DWB-1:0] mem_rdata;

  always #4 clk = ~clk;

  mbist_ctrl #(.NMEM(NM), .AW(AWB), .DW(DWB), .CSR_ADDR(REG)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [NM-1:0] faulty = '0;   // memory i has bit 0 stuck at 1 at word 5

  // memory models
  logic [DWB-1:0] ram [NM][DEPTH];
  logic [DWB-1:0] rq [NM];
  initial begin
    for (int i = 0; i < NM; i++) begin
      rq[i] = '0;
      for (int a = 0; a < DEPTH; a++) ram[i][a] = '0;
    end
  end
  always @(posedge clk) begin
    for (int i = 0; i < NM; i++) begin
      if (mem_en && mem_we) ram[i][mem_addr] <= mem_wdata;
      else if (mem_en) rq[i] <= ram[i][mem_addr] |
             ((faulty[i] && mem_addr == 5) ? 8'h01 : 8'h00);
    end
  end
  always_comb for (int i = 0; i < NM; i++) mem_rdata[i*DWB +: DWB] = rq[i];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference of the status word
  bit m_go, m_chk, m_done, m_busy, was_busy;
  logic [NM-1:0] m_fail;
  int m_cnt;
  logic [31:0] m_word, m_mask;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_go = 0; m_chk = 0; m_done = 0; m_busy = 0; m_fail = '0; m_cnt = 0;
    end else begin
      was_busy = m_busy;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          m_fail = m_chk ? {NM{1'b1}} : faulty;
        end
      end
      if (bus_wr && bus_addr == REG) begin
        if (bus_wdata[2]) begin
          m_go = 0; m_chk = 0; m_done = 0; m_busy = 0; m_fail = '0;
        end else if (!was_busy) begin
          m_go = bus_wdata[1]; m_chk = bus_wdata[0];
          if (m_go || m_chk) begin
            m_busy = 1; m_cnt = RUN_LEN; m_done = 0; m_fail = '0;
          end
        end
      end
      #1;
      m_word = (bus_addr == REG) ? {21'd0, m_fail, m_done, m_go, m_chk} : 32'd0;
      m_mask = m_busy ? 32'h7 : 32'hFFFF_FFFF;
      chk("R1/R3/R5/R7 per-clock word", bus_rdata & m_mask, m_word & m_mask);
      if (!m_busy) chk("R12 idle memory enable", {31'd0, mem_en}, 32'd0);
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = REG; bus_wdata = '0;
  endtask

  task automatic wait_done(output int edges);
    edges = 0;
    while (bus_rdata[2] !== 1'b1 && edges < 1000) begin
      @(posedge clk); #1; edges++;
    end
  endtask

  int n;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset word", bus_rdata, 32'h0);

    // forced-miss self-test
    wr(REG, 32'h1);
    wait_done(n);
    @(negedge clk);
    chk("R6 check-mode result", bus_rdata, 32'h7FD);

    wr(REG, 32'h4);
    chk("R3 clear to zero", bus_rdata, 32'h0);

    // timed healthy run: start edge then count edges to done
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = 32'h2;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    chk("R5 go reads back, done low", bus_rdata, 32'h2);
    wait_done(n);
    chk("R7 edges to done", n, RUN_LEN);
    @(negedge clk);
    chk("R8 healthy result", bus_rdata, 32'h006);

    // stuck bit in memory 3
    wr(REG, 32'h4);
    faulty = 8'b0000_1000;
    wr(REG, 32'h2);
    wait_done(n);
    @(negedge clk);
    chk("R9 only memory 3 flagged", bus_rdata, 32'h046);
    wr(REG, 32'h0);
    repeat (20) @(negedge clk);
    chk("R10 flag sticky after idle write", bus_rdata, 32'h044);

    // other address
    wr(REG, 32'h4);
    faulty = '0;
    @(negedge clk);
    bus_addr = 32'h0420_0004;
    #1 chk("R1 other address reads 0", bus_rdata, 32'h0);
    bus_addr = REG;
    wr(32'h0420_0004, 32'h2);
    repeat (10) @(negedge clk);
    chk("R1 write elsewhere ignored", bus_rdata, 32'h0);

    // clear beats go
    wr(REG, 32'h6);
    repeat (30) @(negedge clk);
    chk("R4 clear wins over go", bus_rdata, 32'h0);

    // writes during a run are ignored
    wr(REG, 32'h2);
    repeat (30) @(negedge clk);
    wr(REG, 32'h1);
    chk("R11 control kept during run", bus_rdata & 32'h7, 32'h2);
    wait_done(n);
    @(negedge clk);
    chk("R11 run unaffected", bus_rdata, 32'h006);

    // clear aborts a run
    wr(REG, 32'h1);
    repeat (40) @(negedge clk);
    wr(REG, 32'h4);
    chk("R3 clear aborts run", bus_rdata, 32'h0);
    repeat (RUN_LEN + 10) @(negedge clk);
    chk("R3 no done after abort", bus_rdata, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule